// File: doc/BRIEF.md
# Masked-Mismatch GPIO Port Pair

This block gives a small microcontroller bus two general-purpose I/O ports of eight pins each. Every port keeps an output latch that sets the level on its pins, together with per-pin output-enable, open-drain mode and analog flags. The bus reaches every register either as a whole byte or as a single bit. A plain read of a port address returns the synchronized pin levels. When the bus flags the access as read-modify-write, the read returns the latch instead, so that the bits the processor changes are based on what it last wrote and not on what the pins show.

Each port also holds a mask and a compare value. The event output is high while either port shows, on its masked pins, a level different from its masked compare value. A sticky status flag records each rising edge of that event until software writes 1 to clear it. A control register holds a pull-up disable bit and a routing enable bit, and the routing enable bit is passed to the surrounding pin-sharing logic.

Register address = port × 8 + field. The fields are: 0 latch, 1 mask, 2 compare, 3 output enable, 4 open-drain mode, 5 analog. Control is at address 16 and status at address 17.

Top module: `gpio_mismatch_port`

## Requirements
- R1: A byte write (bus_bit_en=0) to address p*8+0 stores bus_wdata in port p's latch. With push-pull mode and the output-enable bit set, pad_out[p*8+i] then equals latch bit i and pad_oe[p*8+i] is 1.
- R2: A plain read (bus_rmw=0) of address p*8+0 returns port p's synchronized pin levels, not the latch.
- R3: A read of address p*8+0 with bus_rmw=1 returns port p's latch contents.
- R4: With bus_bit_en=1, a write replaces only bit bus_bit_idx of the addressed register with bus_wdata[0]. A bit read returns the addressed bit in bus_rdata[0], with the other bits at 0.
- R5: evt is 1 exactly when, for some port, (synced pins & mask) differs from (compare & mask). Pins whose mask bit is 0 never affect evt.
- R6: pad_pu[i] is 1 only when the pull-up disable bit (control bit 1) is 0 and the pin's analog flag is 0.
- R7: After reset, the control register reads 0x00: route_en (control bit 0) is 0 and pull-ups are enabled. Writing control bit 0 drives route_en.
- R8: A pin change becomes visible to reads and to evt after exactly two rising clock edges, and not after one.
- R9: evt_flag (also status bit 0) is set at the clock edge that follows a rising edge of evt. It stays set until a write with bit 0 equal to 1 reaches address 17, and a write of 0 leaves it set.
- R10: When a pin's open-drain bit is set, pad_out is 0 and pad_oe is its output-enable bit AND NOT its latch bit. When the output-enable bit is 0, pad_oe is 0.
- R11: After reset, all latch, mask, compare, output-enable, mode and analog bits are 0, so evt, evt_flag and every pad_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_rmw | input | 1 | Read belongs to a read-modify-write access |
| bus_bit_en | input | 1 | Single-bit access |
| bus_bit_idx | input | 3 | Bit index for single-bit access |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 16 | Raw pin levels, port p at bits p*8+7..p*8 |
| pad_out | output | 16 | Pad output level |
| pad_oe | output | 16 | Pad driver enable |
| pad_pu | output | 16 | Weak pull-up enable |
| route_en | output | 1 | Peripheral routing enable |
| evt | output | 1 | Level mismatch event |
| evt_flag | output | 1 | Sticky rising-edge flag of evt |

## Verification
A corrupted latch shows up on pad_out and on a read-modify-write read during the same cycle. A stuck or skipped synchronizer stage shows up as a plain read or an evt edge that arrives one edge early or late, so the bench samples both one and two edges after a pin change. A mask or compare register that is wrong shows only on a masked pin, so the bench toggles masked and unmasked pins separately. A faulty sticky flag shows one edge after evt rises, or after a clearing write.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
// Package: shared register field codes and address layout for the GPIO port pair.
// Assumes each port occupies an aligned window of REG_SPAN addresses.
package gpio_pkg;
    localparam int REG_SPAN = 8;
    localparam int FIELD_W  = 3;

    typedef enum logic [FIELD_W-1:0] {
        F_LATCH = 3'd0,
        F_MASK  = 3'd1,
        F_MATCH = 3'd2,
        F_OE    = 3'd3,
        F_OD    = 3'd4,
        F_ANA   = 3'd5
    } field_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
// Module: gpio_sync
// Multi-stage flop synchronizer for a vector of asynchronous pin levels.
// Assumes each bit is sampled independently (no multi-bit coherence needed).
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the raw levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pad_drv.sv
`timescale 1ns/1ps
// Module: gpio_pad_drv
// Per-pin driver control: push-pull or open-drain output, and pull-up gating.
// Assumes open-drain pins only ever pull low; a high level comes from outside.
module gpio_pad_drv #(
    parameter int W = 8
) (
    input  logic [W-1:0] latch,
    input  logic [W-1:0] oe_bits,
    input  logic [W-1:0] od_bits,
    input  logic [W-1:0] ana_bits,
    input  logic         pud,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        // Open-drain drives 0 only when the latch is 0; push-pull follows the latch.
        assign pad_out[i] = latch[i] & ~od_bits[i];
        assign pad_oe[i]  = oe_bits[i] & ~(od_bits[i] & latch[i]);
        // Weak pull-up unless globally disabled or pin is analog.
        assign pad_pu[i]  = ~pud & ~ana_bits[i];
    end
endmodule

// File: rtl/gpio_lane.sv
`timescale 1ns/1ps
// Module: gpio_lane
// One port: latch, mask, compare, output-enable, mode and analog registers,
// an input synchronizer and the masked mismatch comparator.
// Assumes the parent has already decoded the write to this port.
module gpio_lane
    import gpio_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_field,
    input  logic               bit_en,
    input  logic [IDX_W-1:0]   bit_idx,
    input  logic [W-1:0]       wdata,
    input  logic [W-1:0]       pin_raw,
    output logic [W-1:0]       latch_q,
    output logic [W-1:0]       mask_q,
    output logic [W-1:0]       match_q,
    output logic [W-1:0]       oe_q,
    output logic [W-1:0]       od_q,
    output logic [W-1:0]       ana_q,
    output logic [W-1:0]       pins_s,
    output logic               mismatch
);
    // Merge a byte or single-bit write into an existing register value.
    function automatic logic [W-1:0] merge(input logic [W-1:0] old);
        logic [W-1:0] r;
        r = old;
        if (bit_en) r[bit_idx] = wdata[0];
        else        r = wdata;
        return r;
    endfunction

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_raw),
        .q    (pins_s)
    );

    // Register file update for the addressed field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            mask_q  <= '0;
            match_q <= '0;
            oe_q    <= '0;
            od_q    <= '0;
            ana_q   <= '0;
        end else if (wr_en) begin
            case (wr_field)
                F_LATCH: latch_q <= merge(latch_q);
                F_MASK:  mask_q  <= merge(mask_q);
                F_MATCH: match_q <= merge(match_q);
                F_OE:    oe_q    <= merge(oe_q);
                F_OD:    od_q    <= merge(od_q);
                F_ANA:   ana_q   <= merge(ana_q);
                default: ;
            endcase
        end
    end

    // Masked comparison: event when any enabled pin disagrees with compare value.
    always_comb mismatch = |((pins_s ^ match_q) & mask_q);
endmodule

// File: rtl/gpio_mismatch_port.sv
`timescale 1ns/1ps
// Module: gpio_mismatch_port
// Top of the GPIO port pair: address decode, read mux, control register,
// per-port lanes and pad drivers, event OR and sticky rising-edge flag.
// Assumes single-cycle bus accesses; read data is combinational.
module gpio_mismatch_port
    import gpio_pkg::*;
#(
    parameter int NPORTS      = 2,
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(W),
    localparam int CTRL_A     = NPORTS * REG_SPAN,
    localparam int STAT_A     = CTRL_A + 1,
    localparam int ADDR_W     = $clog2(STAT_A + 1),
    localparam int PG_W       = ADDR_W - FIELD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic                bus_rmw,
    input  logic                bus_bit_en,
    input  logic [IDX_W-1:0]    bus_bit_idx,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [W-1:0]        bus_wdata,
    output logic [W-1:0]        bus_rdata,
    input  logic [NPORTS*W-1:0] pin_in,
    output logic [NPORTS*W-1:0] pad_out,
    output logic [NPORTS*W-1:0] pad_oe,
    output logic [NPORTS*W-1:0] pad_pu,
    output logic                route_en,
    output logic                evt,
    output logic                evt_flag
);
    logic [W-1:0]        latch_a [NPORTS];
    logic [W-1:0]        mask_a  [NPORTS];
    logic [W-1:0]        match_a [NPORTS];
    logic [W-1:0]        oe_a    [NPORTS];
    logic [W-1:0]        od_a    [NPORTS];
    logic [W-1:0]        ana_a   [NPORTS];
    logic [W-1:0]        pins_a  [NPORTS];
    logic [NPORTS-1:0]   mism;
    logic [NPORTS*W-1:0] latch_f, od_f, ana_f;

    logic                wr;
    logic [PG_W-1:0]     pg;
    logic [FIELD_W-1:0]  fld;
    logic                route_q, pud_q, evt_q, flag_q, clr;
    logic [W-1:0]        ctrl_new;
    logic [W-1:0]        word;

    assign wr  = bus_sel & bus_we;
    assign pg  = bus_addr[ADDR_W-1:FIELD_W];
    assign fld = bus_addr[FIELD_W-1:0];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic lane_wr;
        assign lane_wr = wr && (pg == PG_W'(p));

        gpio_lane #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (lane_wr),
            .wr_field(fld),
            .bit_en  (bus_bit_en),
            .bit_idx (bus_bit_idx),
            .wdata   (bus_wdata),
            .pin_raw (pin_in[p*W +: W]),
            .latch_q (latch_a[p]),
            .mask_q  (mask_a[p]),
            .match_q (match_a[p]),
            .oe_q    (oe_a[p]),
            .od_q    (od_a[p]),
            .ana_q   (ana_a[p]),
            .pins_s  (pins_a[p]),
            .mismatch(mism[p])
        );

        gpio_pad_drv #(.W(W)) u_pad (
            .latch   (latch_a[p]),
            .oe_bits (oe_a[p]),
            .od_bits (od_a[p]),
            .ana_bits(ana_a[p]),
            .pud     (pud_q),
            .pad_out (pad_out[p*W +: W]),
            .pad_oe  (pad_oe[p*W +: W]),
            .pad_pu  (pad_pu[p*W +: W])
        );

        assign latch_f[p*W +: W] = latch_a[p];
        assign od_f[p*W +: W]    = od_a[p];
        assign ana_f[p*W +: W]   = ana_a[p];
    end

    // Control write value, merged for byte or single-bit access.
    always_comb begin
        ctrl_new = W'({pud_q, route_q});
        if (bus_bit_en) ctrl_new[bus_bit_idx] = bus_wdata[0];
        else            ctrl_new = bus_wdata;
    end

    // Status clear request: a 1 landing on status bit 0.
    always_comb clr = wr && (bus_addr == ADDR_W'(STAT_A)) &&
                      (bus_bit_en ? (bus_bit_idx == '0) && bus_wdata[0] : bus_wdata[0]);

    // Control register: routing enable (bit 0) and pull-up disable (bit 1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= 1'b0;
            pud_q   <= 1'b0;
        end else if (wr && (bus_addr == ADDR_W'(CTRL_A))) begin
            route_q <= ctrl_new[0];
            pud_q   <= ctrl_new[1];
        end
    end

    // Sticky flag: set on rising event, cleared by write-1; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            evt_q  <= evt;
            flag_q <= (evt & ~evt_q) | (flag_q & ~clr);
        end
    end

    // Read mux: pins on plain reads of a port, latch on read-modify-write.
    always_comb begin
        word = '0;
        if (bus_addr == ADDR_W'(CTRL_A)) begin
            word = W'({pud_q, route_q});
        end else if (bus_addr == ADDR_W'(STAT_A)) begin
            word = W'(flag_q);
        end else begin
            for (int p = 0; p < NPORTS; p++) begin
                if (pg == PG_W'(p)) begin
                    case (fld)
                        F_LATCH: word = bus_rmw ? latch_a[p] : pins_a[p];
                        F_MASK:  word = mask_a[p];
                        F_MATCH: word = match_a[p];
                        F_OE:    word = oe_a[p];
                        F_OD:    word = od_a[p];
                        F_ANA:   word = ana_a[p];
                        default: word = '0;
                    endcase
                end
            end
        end
        bus_rdata = bus_bit_en ? W'(word[bus_bit_idx]) : word;
    end

    assign evt      = |mism;
    assign evt_flag = flag_q;
    assign route_en = route_q;
endmodule

// File: rtl/gpio_mismatch_port_chk.sv
`timescale 1ns/1ps
// Module: gpio_mismatch_port_chk
// Protocol and structural properties of the GPIO port pair, bound into the top.
// Assumes the top's internal flat vectors latch_f, od_f, ana_f and pud_q.
module gpio_mismatch_port_chk #(
    parameter int NPORTS = 2,
    parameter int W      = 8,
    localparam int IDX_W  = $clog2(W),
    localparam int CTRL_A = NPORTS * 8,
    localparam int STAT_A = CTRL_A + 1,
    localparam int ADDR_W = $clog2(STAT_A + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_we,
    input logic                bus_rmw,
    input logic                bus_bit_en,
    input logic [IDX_W-1:0]    bus_bit_idx,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [W-1:0]        bus_wdata,
    input logic [W-1:0]        bus_rdata,
    input logic [NPORTS*W-1:0] pad_out,
    input logic [NPORTS*W-1:0] pad_oe,
    input logic [NPORTS*W-1:0] pad_pu,
    input logic                route_en,
    input logic                evt,
    input logic                evt_flag,
    input logic                pud_q,
    input logic [NPORTS*W-1:0] latch_f,
    input logic [NPORTS*W-1:0] od_f,
    input logic [NPORTS*W-1:0] ana_f
);
    p_rmw_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_rmw && !bus_bit_en && bus_addr == '0)
        |-> bus_rdata == latch_f[W-1:0]);

    p_bit_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_bit_en && bus_addr == '0)
        |=> ((latch_f[W-1:0] ^ $past(latch_f[W-1:0])) & ~(W'(1) << $past(bus_bit_idx))) == '0);

    p_no_pu_analog_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & ana_f) == '0);

    p_ctrl_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!route_en && !pud_q));

    p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt) |=> evt_flag);

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && !(bus_sel && bus_we && bus_addr == ADDR_W'(STAT_A))) |=> evt_flag);

    p_od_no_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & od_f & pad_out) == '0);
endmodule

bind gpio_mismatch_port gpio_mismatch_port_chk #(.NPORTS(NPORTS), .W(W)) u_chk (.*);

// File: tb/gpio_mismatch_port_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random register and pin traffic,
// checked against a register model kept in the bench.
module gpio_mismatch_port_test;
    localparam int NP = 2;
    localparam int W  = 8;
    localparam logic [4:0] CTRL = 5'd16;
    localparam logic [4:0] STAT = 5'd17;

    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_we = 0, bus_rmw = 0, bus_bit_en = 0;
    logic [2:0] bus_bit_idx = '0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [15:0] pin_in = '0, pad_out, pad_oe, pad_pu;
    logic route_en, evt, evt_flag;

    int total = 0, fails = 0;
    logic [7:0] m_reg [NP][6];
    logic [1:0] m_ctrl;

    always #10 clk = ~clk;

    gpio_mismatch_port uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_rmw(bus_rmw), .bus_bit_en(bus_bit_en), .bus_bit_idx(bus_bit_idx),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .route_en(route_en), .evt(evt), .evt_flag(evt_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_evt();
        logic e = 0;
        for (int p = 0; p < NP; p++)
            if (((pin_in[p*8 +: 8] ^ m_reg[p][2]) & m_reg[p][1]) != 0) e = 1;
        return e;
    endfunction

    function automatic logic [15:0] exp_out();
        logic [15:0] v;
        for (int p = 0; p < NP; p++) v[p*8 +: 8] = m_reg[p][0] & ~m_reg[p][4];
        return v;
    endfunction

    function automatic logic [15:0] exp_oe();
        logic [15:0] v;
        for (int p = 0; p < NP; p++) v[p*8 +: 8] = m_reg[p][3] & ~(m_reg[p][4] & m_reg[p][0]);
        return v;
    endfunction

    function automatic logic [15:0] exp_pu();
        logic [15:0] v;
        for (int p = 0; p < NP; p++) v[p*8 +: 8] = m_ctrl[1] ? 8'h00 : ~m_reg[p][5];
        return v;
    endfunction

    // Byte write; returns at the negedge after the capturing edge.
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_bit_en = 0; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic wrbit(input logic [4:0] a, input logic [2:0] idx, input logic v);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_bit_en = 1; bus_bit_idx = idx; bus_addr = a;
        bus_wdata = {7'b0, v};
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_bit_en = 0;
    endtask

    // Port-register write with model update.
    task automatic mwr(input int p, input int f, input logic [7:0] d);
        wr(5'(p*8 + f), d);
        m_reg[p][f] = d;
    endtask

    // Combinational read, called just after a negedge.
    task automatic rd(input logic [4:0] a, input logic rmw, input logic be,
                      input logic [2:0] idx, output logic [7:0] d);
        bus_sel = 1; bus_we = 0; bus_addr = a; bus_rmw = rmw; bus_bit_en = be; bus_bit_idx = idx;
        #2;
        d = bus_rdata;
        bus_sel = 0; bus_rmw = 0; bus_bit_en = 0;
    endtask

    initial begin
        #4_000_000;
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240607));
        for (int p = 0; p < NP; p++) for (int f = 0; f < 6; f++) m_reg[p][f] = '0;
        m_ctrl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state
        rd(CTRL, 0, 0, 0, d);   chk("R7 control reset", d, 8'h00);
        chk("R7 route_en reset", route_en, 1'b0);
        chk("R6 pull-ups after reset", pad_pu, 16'hFFFF);
        chk("R11 pad_oe reset", pad_oe, 16'h0000);
        chk("R11 evt reset", evt, 1'b0);
        chk("R11 flag reset", evt_flag, 1'b0);
        rd(5'd8, 1, 0, 0, d);   chk("R11 latch reset", d, 8'h00);

        // R1 latch drives pads
        mwr(0, 0, 8'hA5); mwr(0, 3, 8'hFF);
        chk("R1 pad_out", pad_out[7:0], 8'hA5);
        chk("R1 pad_oe", pad_oe[7:0], 8'hFF);

        // R2 / R3 plain vs read-modify-write read
        pin_in[7:0] = 8'h3C;
        repeat (3) @(negedge clk);
        rd(5'd0, 0, 0, 0, d);   chk("R2 plain read pins", d, 8'h3C);
        rd(5'd0, 1, 0, 0, d);   chk("R3 rmw read latch", d, 8'hA5);

        // R8 two-edge synchronizer latency on port 1
        @(negedge clk);
        pin_in[15:8] = 8'h5A;
        @(negedge clk);
        rd(5'd8, 0, 0, 0, d);   chk("R8 after one edge", d, 8'h00);
        @(negedge clk);
        rd(5'd8, 0, 0, 0, d);   chk("R8 after two edges", d, 8'h5A);

        // R4 single-bit access
        mwr(1, 0, 8'h0F);
        wrbit(5'd8, 3'd6, 1'b1); m_reg[1][0] = 8'h4F;
        rd(5'd8, 1, 0, 0, d);   chk("R4 bit set", d, 8'h4F);
        wrbit(5'd8, 3'd1, 1'b0); m_reg[1][0] = 8'h4D;
        rd(5'd8, 1, 0, 0, d);   chk("R4 bit clear", d, 8'h4D);
        rd(5'd8, 1, 1, 3'd6, d); chk("R4 bit read one", d, 8'h01);
        rd(5'd8, 1, 1, 3'd1, d); chk("R4 bit read zero", d, 8'h00);

        // R5 masked mismatch on port 1 (pins 0x5A)
        mwr(1, 2, 8'h50); mwr(1, 1, 8'hF0);
        chk("R5 masked equal no event", evt, 1'b0);
        pin_in[8] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 unmasked pin ignored", evt, 1'b0);
        pin_in[15] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 masked pin mismatch", evt, 1'b1);
        pin_in[15] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 mismatch gone", evt, 1'b0);

        // R9 sticky flag timing and clearing
        wr(STAT, 8'h01);
        pin_in[15] = 1'b1;
        @(negedge clk);
        chk("R9 evt not yet", evt, 1'b0);
        @(negedge clk);
        chk("R9 evt high", evt, 1'b1);
        chk("R9 flag one edge later", evt_flag, 1'b0);
        @(negedge clk);
        chk("R9 flag set", evt_flag, 1'b1);
        rd(STAT, 0, 0, 0, d);   chk("R9 status bit", d, 8'h01);
        wr(STAT, 8'h00);
        chk("R9 write 0 keeps flag", evt_flag, 1'b1);
        wr(STAT, 8'h01);
        chk("R9 write 1 clears", evt_flag, 1'b0);
        @(negedge clk);
        chk("R9 level alone no reset", evt_flag, 1'b0);
        pin_in[15] = 1'b0;
        mwr(1, 1, 8'h00);

        // R10 open-drain
        mwr(0, 0, 8'h0F); mwr(0, 4, 8'hFF); mwr(0, 3, 8'h3C);
        chk("R10 od pad_out low", pad_out[7:0], 8'h00);
        chk("R10 od pad_oe", pad_oe[7:0], 8'h30);
        mwr(0, 3, 8'h00);
        chk("R10 oe off", pad_oe[7:0], 8'h00);

        // R6 analog and pull-up disable
        mwr(0, 5, 8'h81);
        chk("R6 analog no pull-up", pad_pu[7:0], 8'h7E);
        wr(CTRL, 8'h02); m_ctrl = 2'b10;
        chk("R6 pull-up disable", pad_pu, 16'h0000);
        chk("R7 route still off", route_en, 1'b0);
        wrbit(CTRL, 3'd0, 1'b1); m_ctrl = 2'b11;
        chk("R7 route enable", route_en, 1'b1);
        rd(CTRL, 0, 0, 0, d);   chk("R7 control read", d, 8'h03);

        // Random traffic
        for (int it = 0; it < 300; it++) begin
            int op = $urandom % 4;
            if (op == 0) begin
                pin_in = 16'($urandom);
            end else if (op == 1) begin
                logic [7:0] v = 8'($urandom);
                wr(CTRL, v); m_ctrl = v[1:0];
            end else begin
                mwr($urandom % NP, $urandom % 6, 8'($urandom));
            end
            repeat (3) @(negedge clk);
            chk("R5 random evt", evt, exp_evt());
            chk("R1 random pad_out", pad_out, exp_out());
            chk("R10 random pad_oe", pad_oe, exp_oe());
            chk("R6 random pad_pu", pad_pu, exp_pu());
            chk("R7 random route", route_en, m_ctrl[0]);
            begin
                int p = $urandom % NP;
                rd(5'(p*8), 0, 0, 0, d); chk("R2 random pins", d, pin_in[p*8 +: 8]);
                rd(5'(p*8), 1, 0, 0, d); chk("R3 random latch", d, m_reg[p][0]);
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule